// File: doc/BRIEF.md
# Runtime-Programmable Raster Timing Generator

This block produces the horizontal and vertical scan timing for a display pipeline. Software programs the raster geometry through a small register port. Each 32-bit timing word carries a vertical quantity in its upper half and a horizontal quantity in its lower half. The active size and the total size are written as the count minus one. The front porch and the sync width are written as plain counts. The back porch is whatever remains between the end of sync and the total.

A pixel counter and a line counter run once the enable bit is set. From them the block derives active-low horizontal and vertical sync, a data-enable strobe, and the pixel coordinates inside the visible area. The status word also carries a pixel-clock select and a pixel-format code. The block passes these, together with a frame base address, unchanged to the clock and fetch logic downstream. Timing words are copied into working registers at frame boundaries, so software can reprogram the geometry while the display is running without tearing the frame in progress.

Top module: `vid_raster_gen`

## Requirements
- R1: After reset every register reads 0, `vid_en` is 0, `hsync_n` and `vsync_n` are 1, `de` is 0, and `px_x`/`px_y` are 0.
- R2: Word registers are decoded from `reg_addr[4:2]`: 0 status, 1 active size, 2 front porch, 3 sync width, 4 total, 5 frame base. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` returns the selected register combinationally. Status keeps only bits 0, 5:4 and 7:6 (read mask 0x000000F1). Addresses 6 and 7 read 0, and writes to them change nothing.
- R3: `vid_en` = status bit 0, `pix_fmt` = status bits 5:4 (1 = 8 bpp, 2 = 16 bpp, 3 = 32 bpp), and `pclk_sel` = status bits 7:6. All three follow the register from the cycle after the write.
- R4: While enabled, the pixel counter counts 0..Htot and wraps, where Htot is total[15:0]. The line counter advances on each wrap and runs 0..Vtot, where Vtot is total[31:16]. One frame lasts (Htot+1)*(Vtot+1) cycles.
- R5: `de` is 1 exactly when pixel ≤ act[15:0] and line ≤ act[31:16]. While `de` is 1, `px_x`/`px_y` equal the pixel and line counts; otherwise they are 0.
- R6: `hsync_n` is 0 exactly for pixel counts P with act[15:0]+1+fp[15:0] ≤ P < that value + sync[15:0]. A sync width of 0 gives no pulse.
- R7: `vsync_n` is 0 exactly for line counts L with act[31:16]+1+fp[31:16] ≤ L < that value + sync[31:16].
- R8: While `vid_en` is 0, both counters are held at 0 and the outputs are inactive (`hsync_n`=`vsync_n`=1, `de`=0), starting from the cycle after the disabling write. In the first cycle after an enabling write, the raster is at pixel 0, line 0.
- R9: Writes to the active, porch, sync or total registers made during an enabled frame do not change the timing until the cycle after the last pixel of the last line.
- R10: `fb_base` equals the frame-base register from the cycle after its write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| vid_en | output | 1 | Display enable from status |
| pclk_sel | output | 2 | Pixel clock select |
| pix_fmt | output | 2 | Pixel format code |
| fb_base | output | 32 | Frame base address |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable in active area |
| px_x | output | 16 | Active-area pixel column |
| px_y | output | 16 | Active-area line |

## Verification
The bench targets three kinds of geometry: degenerate ones (one-pixel active width, zero porches, zero sync width), sync pulses that end exactly at the total, and geometry rewritten halfway through a frame. A design with an off-by-one in the minus-one decoding would shift `de` or the sync edge by one pixel, and the per-cycle comparison would catch it. A design that used new timing at once would start a short or long frame, and this shows up both in the mid-frame comparison and in the measured vsync period. Disabling mid-frame and then re-enabling checks that the counters restart at the origin and do not resume where they stopped.

// File: rtl/vid_raster_gen.sv
module vid_raster_gen #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              vid_en,
  output logic [1:0]        pclk_sel,
  output logic [1:0]        pix_fmt,
  output logic [31:0]       fb_base,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [15:0]       px_x,
  output logic [15:0]       px_y
);
  localparam int HW    = 16;
  localparam int IDX_W = ADDR_W - 2;
  localparam int EW    = HW + 2;

  logic          st_en;
  logic [1:0]    st_fmt, st_clk;
  logic [31:0]   r_act, r_fp, r_sy, r_tot, r_base;
  logic [31:0]   s_act, s_fp, s_sy, s_tot;
  logic [HW-1:0] hc, vc;
  logic [IDX_W-1:0] idx;

  assign idx = reg_addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_en  <= 1'b0;
      st_fmt <= '0;
      st_clk <= '0;
      r_act  <= '0;
      r_fp   <= '0;
      r_sy   <= '0;
      r_tot  <= '0;
      r_base <= '0;
    end else if (reg_wr) begin
      case (idx)
        IDX_W'(0): begin
          st_en  <= reg_wdata[0];
          st_fmt <= reg_wdata[5:4];
          st_clk <= reg_wdata[7:6];
        end
        IDX_W'(1): r_act  <= reg_wdata;
        IDX_W'(2): r_fp   <= reg_wdata;
        IDX_W'(3): r_sy   <= reg_wdata;
        IDX_W'(4): r_tot  <= reg_wdata;
        IDX_W'(5): r_base <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_W'(0): reg_rdata = {24'd0, st_clk, st_fmt, 3'd0, st_en};
      IDX_W'(1): reg_rdata = r_act;
      IDX_W'(2): reg_rdata = r_fp;
      IDX_W'(3): reg_rdata = r_sy;
      IDX_W'(4): reg_rdata = r_tot;
      IDX_W'(5): reg_rdata = r_base;
      default:   reg_rdata = '0;
    endcase
  end

  assign vid_en   = st_en;
  assign pix_fmt  = st_fmt;
  assign pclk_sel = st_clk;
  assign fb_base  = r_base;

  logic h_last, v_last, frame_end;
  assign h_last    = (hc == s_tot[HW-1:0]);
  assign v_last    = (vc == s_tot[31:16]);
  assign frame_end = h_last && v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_act <= '0;
      s_fp  <= '0;
      s_sy  <= '0;
      s_tot <= '0;
    end else if (!st_en || frame_end) begin
      s_act <= r_act;
      s_fp  <= r_fp;
      s_sy  <= r_sy;
      s_tot <= r_tot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (!st_en) begin
      hc <= '0;
      vc <= '0;
    end else if (h_last) begin
      hc <= '0;
      vc <= v_last ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  logic [EW-1:0] hs_beg, hs_end, vs_beg, vs_end;
  logic          hs_on, vs_on, in_act;

  assign hs_beg = EW'(s_act[HW-1:0]) + EW'(s_fp[HW-1:0]) + EW'(1);
  assign hs_end = hs_beg + EW'(s_sy[HW-1:0]);
  assign vs_beg = EW'(s_act[31:16]) + EW'(s_fp[31:16]) + EW'(1);
  assign vs_end = vs_beg + EW'(s_sy[31:16]);

  assign hs_on  = (EW'(hc) >= hs_beg) && (EW'(hc) < hs_end);
  assign vs_on  = (EW'(vc) >= vs_beg) && (EW'(vc) < vs_end);
  assign in_act = (hc <= s_act[HW-1:0]) && (vc <= s_act[31:16]);

  assign hsync_n = !(st_en && hs_on);
  assign vsync_n = !(st_en && vs_on);
  assign de      = st_en && in_act;
  assign px_x    = de ? hc : '0;
  assign px_y    = de ? vc : '0;

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |=> (hc == '0 && vc == '0)); // R8
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !h_last) |=> (hc == $past(hc) + 16'd1)); // R4
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && h_last) |=> (hc == '0)); // R4
  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !h_last) |=> (vc == $past(vc))); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !frame_end) |=> (s_tot == $past(s_tot) && s_act == $past(s_act)
                               && s_fp == $past(s_fp) && s_sy == $past(s_sy))); // R9
endmodule

// File: tb/test_vid_raster_gen.sv
module test_vid_raster_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, fb_base;
  logic        vid_en, hsync_n, vsync_n, de;
  logic [1:0]  pclk_sel, pix_fmt;
  logic [15:0] px_x, px_y;

  always #10 clk = ~clk;

  vid_raster_gen #(.ADDR_W(5)) i_vid_raster_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vid_en(vid_en),
    .pclk_sel(pclk_sel), .pix_fmt(pix_fmt), .fb_base(fb_base),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .px_x(px_x), .px_y(px_y));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit m_en = 0;
  int m_h = 0, m_v = 0;
  logic [31:0] r_st = 0, r_act = 0, r_fp = 0, r_sy = 0, r_tot = 0, r_base = 0;
  logic [31:0] c_act = 0, c_fp = 0, c_sy = 0, c_tot = 0;
  int cyc_n = 0, last_fall = -1;
  bit chk_per = 0;
  logic prev_vs = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int frame_len(input logic [31:0] t);
    return (int'(t[15:0]) + 1) * (int'(t[31:16]) + 1);
  endfunction

  task automatic compare();
    int hb, he, vb, ve;
    bit e_de, e_hs, e_vs;
    int e_x, e_y;
    string rq;
    hb = int'(c_act[15:0]) + int'(c_fp[15:0]) + 1;
    he = hb + int'(c_sy[15:0]);
    vb = int'(c_act[31:16]) + int'(c_fp[31:16]) + 1;
    ve = vb + int'(c_sy[31:16]);
    e_de = m_en && m_h <= int'(c_act[15:0]) && m_v <= int'(c_act[31:16]);
    e_hs = !(m_en && m_h >= hb && m_h < he);
    e_vs = !(m_en && m_v >= vb && m_v < ve);
    e_x = e_de ? m_h : 0;
    e_y = e_de ? m_v : 0;
    if (!m_en) rq = "R8";
    else if (r_act != c_act || r_fp != c_fp || r_sy != c_sy || r_tot != c_tot) rq = "R9";
    else rq = "";
    check(de == e_de && int'(px_x) == e_x && int'(px_y) == e_y, rq == "" ? "R5" : rq,
          "de/x/y", {de, px_x, px_y}, {e_de, e_x[15:0], e_y[15:0]});
    check(hsync_n == e_hs, rq == "" ? "R6" : rq, "hsync_n", hsync_n, e_hs);
    check(vsync_n == e_vs, rq == "" ? "R7" : rq, "vsync_n", vsync_n, e_vs);
    cyc_n++;
    if (prev_vs && !vsync_n) begin
      if (chk_per && last_fall >= 0)
        check(cyc_n - last_fall == frame_len(c_tot), "R4", "frame period",
              cyc_n - last_fall, frame_len(c_tot));
      last_fall = cyc_n;
    end
    prev_vs = vsync_n;
  endtask

  task automatic step(input bit wr, input logic [4:0] a, input logic [31:0] d);
    bit fe;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (!m_en) begin
      m_h = 0; m_v = 0;
      c_act = r_act; c_fp = r_fp; c_sy = r_sy; c_tot = r_tot;
    end else begin
      fe = (m_h == int'(c_tot[15:0])) && (m_v == int'(c_tot[31:16]));
      if (m_h == int'(c_tot[15:0])) begin
        m_h = 0;
        m_v = (m_v == int'(c_tot[31:16])) ? 0 : m_v + 1;
      end else m_h = m_h + 1;
      if (fe) begin c_act = r_act; c_fp = r_fp; c_sy = r_sy; c_tot = r_tot; end
    end
    if (wr) case (a[4:2])
      3'd0: r_st = d & 32'h0000_00F1;
      3'd1: r_act = d;
      3'd2: r_fp = d;
      3'd3: r_sy = d;
      3'd4: r_tot = d;
      3'd5: r_base = d;
      default: ;
    endcase
    m_en = r_st[0];
    @(negedge clk);
    reg_wr = 1'b0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 5'h1C, 32'd0);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, "read", reg_rdata, exp);
  endtask

  task automatic setup(input int aw, input int hf, input int hs, input int hb,
                       input int ah, input int vf, input int vs, input int vb);
    step(1'b1, 5'h04, {ah[15:0], aw[15:0]});
    step(1'b1, 5'h08, {vf[15:0], hf[15:0]});
    step(1'b1, 5'h0C, {vs[15:0], hs[15:0]});
    step(1'b1, 5'h10, {16'(ah + vf + vs + vb), 16'(aw + hf + hs + hb)});
  endtask

  task automatic run_cfg(input int aw, input int hf, input int hs, input int hb,
                         input int ah, input int vf, input int vs, input int vb,
                         input logic [1:0] ck, input logic [1:0] fm);
    step(1'b1, 5'h00, 32'd0);
    setup(aw, hf, hs, hb, ah, vf, vs, vb);
    step(1'b1, 5'h00, {24'd0, ck, fm, 4'b0001});
    check(vid_en == 1'b1 && pclk_sel == ck && pix_fmt == fm, "R3", "status outs",
          {vid_en, pclk_sel, pix_fmt}, {1'b1, ck, fm});
    check(de && px_x == 0 && px_y == 0, "R8", "origin after enable",
          {de, px_x, px_y}, {1'b1, 32'd0});
    chk_per = 1; last_fall = -1;
    idle(frame_len(r_tot) * 2 + 7);
    chk_per = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R4 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(hsync_n && vsync_n && !de && !vid_en && px_x == 0 && px_y == 0, "R1",
          "outputs in reset", {hsync_n, vsync_n, de, vid_en}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) rd(5'(a * 4), 32'd0, "R1");
    check(fb_base == 0 && pclk_sel == 0 && pix_fmt == 0, "R1", "side outs",
          {fb_base, pclk_sel, pix_fmt}, 36'd0);

    step(1'b1, 5'h14, 32'hDEAD_BEE0);
    rd(5'h14, 32'hDEAD_BEE0, "R2");
    check(fb_base == 32'hDEAD_BEE0, "R10", "fb_base", fb_base, 32'hDEAD_BEE0);
    step(1'b1, 5'h07, 32'h1234_5678);
    rd(5'h04, 32'h1234_5678, "R2");
    step(1'b1, 5'h04, 32'd0);
    step(1'b1, 5'h18, 32'hFFFF_FFFF);
    rd(5'h18, 32'd0, "R2");
    rd(5'h1C, 32'd0, "R2");
    rd(5'h14, 32'hDEAD_BEE0, "R2");
    step(1'b1, 5'h00, 32'hFFFF_FFFF);
    rd(5'h00, 32'h0000_00F1, "R2");
    check(vid_en && pclk_sel == 2'd3 && pix_fmt == 2'd3, "R3", "all ones",
          {vid_en, pclk_sel, pix_fmt}, 5'h1F);
    idle(3);
    step(1'b1, 5'h00, 32'h0000_0060);
    check(!vid_en && pclk_sel == 2'd1 && pix_fmt == 2'd2, "R3", "fields",
          {vid_en, pclk_sel, pix_fmt}, 5'b0_01_10);

    run_cfg(0, 0, 1, 0, 0, 0, 1, 0, 2'd0, 2'd1);
    run_cfg(3, 0, 0, 0, 2, 0, 0, 0, 2'd1, 2'd2);
    run_cfg(7, 2, 3, 0, 4, 1, 2, 0, 2'd2, 2'd3);
    run_cfg(5, 1, 2, 2, 3, 2, 1, 1, 2'd3, 2'd1);

    for (int k = 0; k < 8; k++)
      run_cfg($urandom_range(15, 0), $urandom_range(3, 0), $urandom_range(4, 1),
              $urandom_range(3, 0), $urandom_range(12, 0), $urandom_range(3, 0),
              $urandom_range(3, 1), $urandom_range(3, 0),
              2'($urandom_range(3, 0)), 2'($urandom_range(3, 1)));

    // R9: rewrite geometry mid-frame
    run_cfg(9, 2, 2, 2, 6, 1, 2, 1, 2'd0, 2'd1);
    idle(frame_len(r_tot) / 2);
    setup(4, 1, 1, 1, 3, 1, 1, 0);
    idle(frame_len(c_tot) + frame_len(r_tot) * 2 + 3);
    check(c_tot == r_tot, "R9", "new timing adopted", c_tot, r_tot);

    // R8: disable mid-frame, hold, then re-enable
    idle(17);
    step(1'b1, 5'h00, 32'd0);
    check(hsync_n && vsync_n && !de, "R8", "quiet when off",
          {hsync_n, vsync_n, de}, 3'b110);
    idle(9);
    step(1'b1, 5'h00, 32'd1);
    check(de && px_x == 0 && px_y == 0, "R8", "restart origin",
          {de, px_x, px_y}, {1'b1, 32'd0});
    idle(40);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule